// File: doc/BRIEF.md
# PAM4 Gray-Coded Burst Error Injector

This block sits in a digital lane that carries 2-bit Gray-coded four-level symbols and corrupts some of them on purpose, so that a forward error correction decoder further down the path sees correlated line errors rather than isolated bit flips. Every corruption is a single-level slip of the four-level value, up or down. Under the Gray map such a slip changes exactly one of the two bits.

Errors arrive in bursts that follow a two-state Markov process driven by a 32-bit LFSR. While no burst is running, each valid symbol may open one, with a probability set by `start_thr`. While a burst is running, each valid symbol keeps it going, with a probability set by `cont_thr`. The first symbol that is left clean ends the burst. Two counters report the injected symbol errors and bit errors. A single register stage sits between input and output.

Top module: `pam4_burst_injector`

## Requirements
- R1: Symbol bits `[1:0]` encode the levels 0, 1, 2 and 3 as 2'b00, 2'b01, 2'b11 and 2'b10. Each corrupted output is the code of a level adjacent to the input level.
- R2: `out_valid` equals `in_valid` delayed by one clock. A symbol that is not corrupted appears unchanged on `out_sym` one clock after it is accepted.
- R3: A corrupted symbol differs from its input by exactly one level, so exactly one of its two bits differs.
- R4: A corrupted level 0 always becomes level 1 (2'b01). A corrupted level 3 always becomes level 2 (2'b11).
- R5: A probability event fires when the 16-bit random draw is below the threshold, or always when the threshold is 16'hFFFF. With `start_thr` = 0, no symbol is ever corrupted.
- R6: Inside a burst, each valid symbol is corrupted with the continuation probability. With both thresholds at 16'hFFFF, every valid symbol is corrupted. With `start_thr` = 16'hFFFF and `cont_thr` = 0, corrupted and clean symbols alternate.
- R7: While `enable` is low, symbols pass through unchanged, nothing is counted, and any open burst is closed.
- R8: `sym_err_cnt` counts corrupted symbols and `bit_err_cnt` counts flipped bits. Both change in the same clock as the corrupted output. A `clear` pulse zeroes both, and it takes priority over an increment in the same clock.
- R9: Reset drives `out_valid` low, `out_sym` to 2'b00 and both counters to 0.
- R10: With `start_thr` = 16'h4000 and `cont_thr` = 16'hC000, the mean burst length over a long run lies between 3 and 5.5 symbols. Inner levels slip in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Corruption enable; low gives a clean bypass |
| clear | input | 1 | Synchronous clear of both counters |
| start_thr | input | 16 | Burst start threshold |
| cont_thr | input | 16 | Burst continuation threshold |
| in_valid | input | 1 | Input symbol valid |
| in_sym | input | 2 | Gray-coded input symbol |
| out_valid | output | 1 | Output symbol valid |
| out_sym | output | 2 | Gray-coded output symbol |
| sym_err_cnt | output | CNT_W | Injected symbol error count |
| bit_err_cnt | output | CNT_W | Injected bit error count |

## Verification
The bound checker watches, on every clock, the properties that hold for any random draw:
- the one-clock valid latency;
- the slip of at most one level;
- clean bypass while disabled;
- the counters stepping by at most one, returning to zero after a clear, and staying equal to each other.

Only the bench's scenarios can show the following:
- the effect of the thresholds, including no errors at zero, all errors at full scale, and strict alternation when continuation is zero;
- the inward-only slips at the outer levels;
- the priority of clear over a same-clock error;
- the statistics of burst length and slip direction at mid-range settings.

// File: rtl/pam4_inj_pkg.sv
package pam4_inj_pkg;

    localparam int RND_W = 32;
    localparam int THR_W = 16;
    localparam logic [RND_W-1:0] LFSR_MASK = 32'h8020_0003;

    typedef logic [1:0] sym_t;
    typedef logic [1:0] lvl_t;

    typedef struct packed {
        logic hit;   // corrupt this symbol
        logic up;    // slip direction
    } inj_dec_t;

    function automatic lvl_t gray_to_lvl(sym_t s);
        case (s)
            2'b00:   return 2'd0;
            2'b01:   return 2'd1;
            2'b11:   return 2'd2;
            default: return 2'd3;
        endcase
    endfunction

    function automatic sym_t lvl_to_gray(lvl_t l);
        case (l)
            2'd0:    return 2'b00;
            2'd1:    return 2'b01;
            2'd2:    return 2'b11;
            default: return 2'b10;
        endcase
    endfunction

    function automatic logic thr_hit(logic [THR_W-1:0] rnd, logic [THR_W-1:0] thr);
        return (thr == {THR_W{1'b1}}) || (rnd < thr);
    endfunction

    function automatic logic [RND_W-1:0] lfsr_step(logic [RND_W-1:0] s);
        logic [RND_W-1:0] n;
        n = s >> 1;
        if (s[0]) n = n ^ LFSR_MASK;
        return n;
    endfunction

endpackage

// File: rtl/pam4_lfsr.sv
module pam4_lfsr
    import pam4_inj_pkg::*;
#(
    parameter int                STEPS = 16,
    parameter logic [RND_W-1:0]  SEED  = 32'h1D87_2B41
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             adv,
    output logic [RND_W-1:0] rnd
);
    logic [RND_W-1:0] nxt;

    // several shifts per symbol decorrelate successive draws
    always_comb begin
        nxt = rnd;
        for (int i = 0; i < STEPS; i++) nxt = lfsr_step(nxt);
    end

    always_ff @(posedge clk) begin
        if (rst)      rnd <= SEED;
        else if (adv) rnd <= nxt;
    end
endmodule

// File: rtl/pam4_burst_ctl.sv
module pam4_burst_ctl
    import pam4_inj_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic             in_valid,
    input  sym_t             in_sym,
    input  logic [RND_W-1:0] rnd,
    input  logic [THR_W-1:0] start_thr,
    input  logic [THR_W-1:0] cont_thr,
    output inj_dec_t         dec
);
    logic in_burst_q;
    lvl_t lvl;
    logic draw;

    always_comb begin
        lvl  = gray_to_lvl(in_sym);
        draw = in_burst_q ? thr_hit(rnd[THR_W-1:0], cont_thr)
                          : thr_hit(rnd[THR_W-1:0], start_thr);
        dec.hit = enable && in_valid && draw;
        if (lvl == 2'd0)      dec.up = 1'b1;
        else if (lvl == 2'd3) dec.up = 1'b0;
        else                  dec.up = rnd[RND_W-1];
    end

    always_ff @(posedge clk) begin
        if (rst || !enable) in_burst_q <= 1'b0;
        else if (in_valid)  in_burst_q <= dec.hit;
    end
endmodule

// File: rtl/pam4_sym_shift.sv
module pam4_sym_shift
    import pam4_inj_pkg::*;
(
    input  sym_t     in_sym,
    input  inj_dec_t dec,
    output sym_t     out_sym
);
    lvl_t lvl;

    always_comb begin
        lvl = gray_to_lvl(in_sym);
        if (!dec.hit)    out_sym = in_sym;
        else if (dec.up) out_sym = lvl_to_gray(lvl + 2'd1);
        else             out_sym = lvl_to_gray(lvl - 2'd1);
    end
endmodule

// File: rtl/pam4_err_cnt.sv
module pam4_err_cnt #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             inc_en,
    input  logic [1:0]       inc,
    output logic [CNT_W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (rst || clr)  cnt <= '0;
        else if (inc_en) cnt <= cnt + CNT_W'(inc);
    end
endmodule

// File: rtl/pam4_burst_injector.sv
module pam4_burst_injector
    import pam4_inj_pkg::*;
#(
    parameter int               CNT_W     = 32,
    parameter int               LFSR_STEP = 16,
    parameter logic [RND_W-1:0] LFSR_SEED = 32'h1D87_2B41
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic             clear,
    input  logic [15:0]      start_thr,
    input  logic [15:0]      cont_thr,
    input  logic             in_valid,
    input  logic [1:0]       in_sym,
    output logic             out_valid,
    output logic [1:0]       out_sym,
    output logic [CNT_W-1:0] sym_err_cnt,
    output logic [CNT_W-1:0] bit_err_cnt
);
    logic [RND_W-1:0] rnd;
    inj_dec_t         dec;
    sym_t             corr_sym;
    sym_t             diff;
    logic [1:0]       nbits;

    pam4_lfsr #(.STEPS(LFSR_STEP), .SEED(LFSR_SEED)) u_lfsr (
        .clk(clk), .rst(rst), .adv(in_valid), .rnd(rnd)
    );

    pam4_burst_ctl u_ctl (
        .clk(clk), .rst(rst), .enable(enable), .in_valid(in_valid),
        .in_sym(in_sym), .rnd(rnd), .start_thr(start_thr),
        .cont_thr(cont_thr), .dec(dec)
    );

    pam4_sym_shift u_shift (
        .in_sym(in_sym), .dec(dec), .out_sym(corr_sym)
    );

    always_comb begin
        diff  = in_sym ^ corr_sym;
        nbits = {1'b0, diff[0]} + {1'b0, diff[1]};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_sym   <= 2'b00;
        end else begin
            out_valid <= in_valid;
            if (in_valid) out_sym <= corr_sym;
        end
    end

    pam4_err_cnt #(.CNT_W(CNT_W)) u_sym_cnt (
        .clk(clk), .rst(rst), .clr(clear), .inc_en(dec.hit),
        .inc(2'd1), .cnt(sym_err_cnt)
    );

    pam4_err_cnt #(.CNT_W(CNT_W)) u_bit_cnt (
        .clk(clk), .rst(rst), .clr(clear), .inc_en(in_valid),
        .inc(nbits), .cnt(bit_err_cnt)
    );
endmodule

// File: rtl/pam4_burst_injector_chk.sv
module pam4_burst_injector_chk
    import pam4_inj_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             enable,
    input logic             clear,
    input logic             in_valid,
    input logic [1:0]       in_sym,
    input logic             out_valid,
    input logic [1:0]       out_sym,
    input logic [CNT_W-1:0] sym_err_cnt,
    input logic [CNT_W-1:0] bit_err_cnt
);
    function automatic int lvl_dist(logic [1:0] a, logic [1:0] b);
        int la, lb;
        la = int'(gray_to_lvl(a));
        lb = int'(gray_to_lvl(b));
        return (la > lb) ? la - lb : lb - la;
    endfunction

    // R2
    valid_latency_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> out_valid == $past(in_valid));

    // R3
    one_level_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> lvl_dist(out_sym, $past(in_sym)) <= 1);

    // R7
    bypass_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !enable) |=> out_sym == $past(in_sym));

    // R8
    clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
        clear |=> (sym_err_cnt == '0) && (bit_err_cnt == '0));

    // R8
    count_step_chk: assert property (@(posedge clk) disable iff (rst)
        !clear |=> (sym_err_cnt == $past(sym_err_cnt)) ||
                   (sym_err_cnt == $past(sym_err_cnt) + 1'b1));

    // R3
    bits_eq_syms_chk: assert property (@(posedge clk) disable iff (rst)
        bit_err_cnt == sym_err_cnt);
endmodule

bind pam4_burst_injector pam4_burst_injector_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .enable(enable), .clear(clear),
    .in_valid(in_valid), .in_sym(in_sym), .out_valid(out_valid),
    .out_sym(out_sym), .sym_err_cnt(sym_err_cnt), .bit_err_cnt(bit_err_cnt)
);

// File: tb/pam4_burst_injector_tb.sv
module pam4_burst_injector_tb;
    localparam int CNT_W = 32;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic enable = 1'b0;
    logic clear = 1'b0;
    logic [15:0] start_thr = '0;
    logic [15:0] cont_thr = '0;
    logic in_valid = 1'b0;
    logic [1:0] in_sym = 2'b00;
    logic out_valid;
    logic [1:0] out_sym;
    logic [CNT_W-1:0] sym_err_cnt, bit_err_cnt;

    always #4 clk = ~clk;  // 125 MHz

    pam4_burst_injector #(.CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst(rst), .enable(enable), .clear(clear),
        .start_thr(start_thr), .cont_thr(cont_thr), .in_valid(in_valid),
        .in_sym(in_sym), .out_valid(out_valid), .out_sym(out_sym),
        .sym_err_cnt(sym_err_cnt), .bit_err_cnt(bit_err_cnt)
    );

    // modes: 0 none allowed, 1 all corrupted, 2 alternate, 3 statistics
    typedef struct {
        logic [1:0] sym;
        logic       en;
        logic       clr;
        int         mode;
    } item_t;

    item_t q[$];
    int checks = 0, failures = 0;
    int cur_mode = 0;
    int exp_sym = 0, exp_bit = 0;
    logic prev_err = 1'b0;
    int run = 0, runs = 0, run_sum = 0;
    bit seen_up = 0, seen_dn = 0;
    bit done = 0;

    function automatic int lvl_of(logic [1:0] s);
        case (s)
            2'b00: return 0;
            2'b01: return 1;
            2'b11: return 2;
            default: return 3;
        endcase
    endfunction

    function automatic int ones(logic [1:0] x);
        return int'(x[0]) + int'(x[1]);
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic drive(logic [1:0] s, logic en, logic clr);
        item_t it;
        @(negedge clk);
        enable   = en;
        clear    = clr;
        in_sym   = s;
        in_valid = 1'b1;
        it.sym = s; it.en = en; it.clr = clr; it.mode = cur_mode;
        q.push_back(it);
    endtask

    task automatic idle(int n);
        @(negedge clk);
        in_valid = 1'b0;
        clear    = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic check_counts(string req);
        check(sym_err_cnt == CNT_W'(exp_sym), req, "sym_err_cnt", int'(sym_err_cnt), exp_sym);
        check(bit_err_cnt == CNT_W'(exp_bit), req, "bit_err_cnt", int'(bit_err_cnt), exp_bit);
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (q.size() == 0) begin
                check(1'b0, "R2", "output without input", 1, 0);
            end else begin
                item_t it;
                int li, lo, d;
                logic err;
                it  = q.pop_front();
                li  = lvl_of(it.sym);
                lo  = lvl_of(out_sym);
                d   = (li > lo) ? li - lo : lo - li;
                err = (out_sym != it.sym);
                if (!it.en) begin
                    check(!err, "R7", "bypass symbol", int'(out_sym), int'(it.sym));
                    prev_err = 1'b0;
                end else begin
                    check(d <= 1, "R1", "level distance", d, 1);
                    if (err) begin
                        check(ones(out_sym ^ it.sym) == 1, "R3", "bits flipped",
                              ones(out_sym ^ it.sym), 1);
                        if (li == 0) check(out_sym == 2'b01, "R4", "slip from level 0",
                                           int'(out_sym), 1);
                        if (li == 3) check(out_sym == 2'b11, "R4", "slip from level 3",
                                           int'(out_sym), 3);
                        if (li == 1 || li == 2) begin
                            if (lo > li) seen_up = 1;
                            else         seen_dn = 1;
                        end
                        if (!it.clr) begin
                            exp_sym++;
                            exp_bit += ones(out_sym ^ it.sym);
                        end
                    end
                    case (it.mode)
                        0: check(!err, "R5", "corruption with zero start", int'(err), 0);
                        1: check(err, "R6", "symbol left clean", int'(err), 1);
                        2: check(err != prev_err, "R6", "alternation", int'(err), int'(!prev_err));
                        default: begin
                            if (err) run++;
                            else if (run > 0) begin
                                runs++; run_sum += run; run = 0;
                            end
                        end
                    endcase
                    prev_err = err;
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        // R9 reset state
        check(out_valid == 1'b0, "R9", "out_valid in reset", int'(out_valid), 0);
        check(out_sym == 2'b00, "R9", "out_sym in reset", int'(out_sym), 0);
        check(sym_err_cnt == '0, "R9", "sym_err_cnt in reset", int'(sym_err_cnt), 0);
        check(bit_err_cnt == '0, "R9", "bit_err_cnt in reset", int'(bit_err_cnt), 0);
        rst = 1'b0;

        // R5 zero start threshold: clean stream, R2 pass-through
        cur_mode = 0; start_thr = 16'h0000; cont_thr = 16'hFFFF;
        for (int i = 0; i < 200; i++) drive(2'((i * 3 + i / 5) % 4), 1'b1, 1'b0);
        idle(3);
        check_counts("R5");

        // R6 full-scale thresholds: every symbol corrupted, R4 edges
        cur_mode = 1; start_thr = 16'hFFFF; cont_thr = 16'hFFFF;
        for (int i = 0; i < 256; i++) drive(2'(i % 4), 1'b1, 1'b0);
        idle(3);
        check_counts("R8");

        // R7 bypass closes the burst and counts nothing
        for (int i = 0; i < 40; i++) drive(2'(i % 4), 1'b0, 1'b0);
        idle(3);
        check_counts("R7");

        // R6 zero continuation: strict alternation from a closed burst
        cur_mode = 2; start_thr = 16'hFFFF; cont_thr = 16'h0000;
        prev_err = 1'b0;
        begin
            int base;
            base = exp_sym;
            for (int i = 0; i < 100; i++) drive(2'((i / 2) % 4), 1'b1, 1'b0);
            idle(3);
            check(exp_sym - base == 50, "R6", "alternating error total", exp_sym - base, 50);
        end
        check_counts("R8");

        // R8 clear, then clear against a same-clock error
        @(negedge clk); clear = 1'b1;
        @(negedge clk); clear = 1'b0;
        exp_sym = 0; exp_bit = 0;
        check_counts("R8");
        cur_mode = 1; start_thr = 16'hFFFF; cont_thr = 16'hFFFF;
        drive(2'b00, 1'b1, 1'b1);
        idle(0);
        check_counts("R8");
        drive(2'b10, 1'b1, 1'b0);
        idle(2);
        check_counts("R8");

        // R10 statistics at mid-range thresholds
        cur_mode = 3; start_thr = 16'h4000; cont_thr = 16'hC000;
        for (int i = 0; i < 3000; i++) drive(2'((i * 7 + i / 3) % 4), 1'b1, 1'b0);
        idle(3);
        check_counts("R8");
        check(runs > 50, "R10", "burst count", runs, 51);
        check(2 * run_sum >= 6 * runs && 2 * run_sum <= 11 * runs, "R10",
              "burst length x100", (runs > 0) ? (run_sum * 100) / runs : 0, 400);
        check(seen_up && seen_dn, "R10", "both slip directions",
              int'(seen_up) + int'(seen_dn), 2);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule